// File: doc/BRIEF.md
# Key Event Queue With Running Durations

This block keeps a short circular history of key events. Each slot pairs an 8-bit key code with an 8-bit duration byte. An upstream debouncer delivers one strobe per settled change, together with the code. The slot written most recently is the live slot. Its duration advances on every pulse of a 32 ms timebase until the next event arrives. From then on the duration of that slot is frozen.

A host-side reader always sees one slot on the read outputs. While undelivered slots exist, that is the oldest of them. Once nothing is pending, it is the live slot with its running duration. The host consumes what it has seen with a pop strobe. A popped slot whose key state has already ended is released. A popped live slot stays in place, so the host can poll it freely. An active-low interrupt marks that something new was stored, and an empty flag marks that nothing undelivered remains. A power-down clear or an active-low halt input returns the whole queue to its reset contents.

Top module: `key_event_queue`

## Requirements
- R1: After reset every slot holds code 0xFF and duration 0x00, empty_o is 1, irq_n_o is 1, and the read outputs show 0xFF / 0x00.
- R2: An event strobe stores its code with duration 0x00 in the slot after the live one. In the next cycle irq_n_o is 0 and empty_o is 0.
- R3: Each tick_i pulse raises bits 6..0 of the live slot's duration by one.
- R4: A tick that finds bits 6..0 at 127 wraps them to 0 and sets bit 7. Bit 7 then stays set through later ticks and after the slot stops being live, until the slot is released or the queue is flushed.
- R5: An event freezes the duration of the previous live slot. Only the new slot counts from 0.
- R6: A pop whose shown slot is not live releases that slot, moves the read outputs to the next older pending slot, and drives irq_n_o high.
- R7: A pop whose shown slot is the live one leaves it in place with its code and running duration, sets empty_o, and drives irq_n_o high. irq_n_o stays high through further pops until the next event.
- R8: When nothing is pending, the read outputs show the live slot's code and running duration.
- R9: With all 8 slots pending, a new event overwrites the oldest slot. The next reads then return the other 7 older codes in arrival order, followed by the new code.
- R10: A pop and an event in the same cycle are applied pop first, then event. irq_n_o ends low.
- R11: Pulsing pwr_clr_i high, or holding halt_n_i low, for one cycle restores the reset state of R1.
- R12: A pop with nothing pending leaves the read outputs and empty_o unchanged and keeps irq_n_o high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| halt_n_i | input | 1 | Shutdown request, active low; clears the queue |
| pwr_clr_i | input | 1 | Power-down clear strobe |
| tick_i | input | 1 | 32 ms timebase pulse |
| evt_i | input | 1 | Debounced event strobe |
| evt_code_i | input | 8 | Key code of the event |
| pop_i | input | 1 | Host has consumed the shown slot |
| rd_code_o | output | 8 | Code of the shown slot |
| rd_dur_o | output | 8 | Duration of the shown slot (bit 7 overflow) |
| empty_o | output | 1 | No undelivered slot remains |
| irq_n_o | output | 1 | Interrupt, active low |

## Verification
The hardest states to reach from the ports are the overflow flag and the full-queue overwrite. The overflow flag needs 128 ticks on one live slot. The overwrite needs nine events with no pop between them. The bench reaches both with directed loops after the vector table. It checks that bit 7 survives the freeze caused by the next event, and it drains the queue slot by slot to confirm the surviving order. A pop and an event in the same cycle are also driven while the shown slot is live, which exercises the ordering rule.

// File: rtl/kev_pkg.sv
package kev_pkg;
    localparam int KEV_CODE_W = 8;
    localparam int KEV_CNT_W  = 7;
    localparam int KEV_DEPTH  = 8;

    typedef struct packed {
        logic [KEV_CODE_W-1:0] code;
        logic [KEV_CNT_W:0]    dur;
    } kev_entry_t;

    localparam kev_entry_t KEV_EMPTY_SLOT = '{code: '1, dur: '0};
endpackage

// File: rtl/kev_dur_step.sv
module kev_dur_step #(
    parameter int CNT_W = 7
) (
    input  logic [CNT_W:0] cur_i,
    input  logic           adv_i,
    output logic [CNT_W:0] nxt_o
);
    logic [CNT_W-1:0] low_d;
    logic             of_d;

    always_comb begin
        low_d = cur_i[CNT_W-1:0];
        of_d  = cur_i[CNT_W];
        if (adv_i) begin
            low_d = cur_i[CNT_W-1:0] + 1'b1;
            of_d  = cur_i[CNT_W] | (&cur_i[CNT_W-1:0]);
        end
        nxt_o = {of_d, low_d};
    end
endmodule

// File: rtl/kev_ctrl.sv
module kev_ctrl #(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_B = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             evt_i,
    input  logic             pop_i,
    output logic [PTR_W-1:0] live_o,
    output logic             wr_en_o,
    output logic [PTR_W-1:0] wr_idx_o,
    output logic             clr_en_o,
    output logic [PTR_W-1:0] clr_idx_o,
    output logic [PTR_W-1:0] show_idx_o,
    output logic             empty_o,
    output logic             irq_n_o
);
    typedef struct packed {
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] live;
        logic [CNT_B-1:0] cnt;
        logic             seen;
        logic             pend;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{rd: '0, live: PTR_W'(DEPTH - 1), cnt: '0,
                                   seen: 1'b0, pend: 1'b0};

    ctrl_t ctrl_d, ctrl_q;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        ctrl_d    = ctrl_q;
        wr_en_o   = 1'b0;
        clr_en_o  = 1'b0;
        clr_idx_o = ctrl_q.rd;
        wr_idx_o  = ptr_inc(ctrl_q.live);
        // host side first
        if (pop_i) begin
            ctrl_d.pend = 1'b0;
            if (ctrl_q.cnt != '0 && ctrl_q.rd != ctrl_q.live) begin
                clr_en_o    = 1'b1;
                ctrl_d.rd   = ptr_inc(ctrl_q.rd);
                ctrl_d.cnt  = ctrl_q.cnt - 1'b1;
            end else if (ctrl_q.cnt != '0) begin
                ctrl_d.seen = 1'b1;
            end
        end
        // then the new event
        if (evt_i) begin
            wr_en_o     = 1'b1;
            ctrl_d.live = ptr_inc(ctrl_q.live);
            ctrl_d.seen = 1'b0;
            ctrl_d.pend = 1'b1;
            if (ctrl_d.cnt == CNT_B'(DEPTH))
                ctrl_d.rd = ptr_inc(ctrl_d.rd);
            else
                ctrl_d.cnt = ctrl_d.cnt + 1'b1;
        end
        if (flush_i) begin
            ctrl_d   = CTRL_RST;
            wr_en_o  = 1'b0;
            clr_en_o = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= CTRL_RST;
        else        ctrl_q <= ctrl_d;
    end

    assign live_o     = ctrl_q.live;
    assign show_idx_o = (ctrl_q.cnt == '0) ? ctrl_q.live : ctrl_q.rd;
    assign empty_o    = (ctrl_q.cnt == '0) || (ctrl_q.cnt == CNT_B'(1) && ctrl_q.seen);
    assign irq_n_o    = ~ctrl_q.pend;

    // R9
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.cnt <= CNT_B'(DEPTH));

    // R2
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n_o) |-> $past(evt_i && !flush_i));

    // R6
    pop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !evt_i) |=> irq_n_o);

    // R11
    flush_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (empty_o && irq_n_o && show_idx_o == PTR_W'(DEPTH - 1)));

    // R12
    idle_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !evt_i && !flush_i && ctrl_q.cnt == '0) |=> ($stable(show_idx_o) && empty_o));
endmodule

// File: rtl/kev_store.sv
module kev_store
    import kev_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int CODE_W = 8,
    parameter int CNT_W  = 7,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              tick_i,
    input  logic [PTR_W-1:0]  live_i,
    input  logic              wr_en_i,
    input  logic [PTR_W-1:0]  wr_idx_i,
    input  logic [CODE_W-1:0] wr_code_i,
    input  logic              clr_en_i,
    input  logic [PTR_W-1:0]  clr_idx_i,
    input  logic [PTR_W-1:0]  show_idx_i,
    output logic [CODE_W-1:0] rd_code_o,
    output logic [CNT_W:0]    rd_dur_o
);
    logic [CODE_W-1:0] code_d [DEPTH];
    logic [CODE_W-1:0] code_q [DEPTH];
    logic [CNT_W:0]    dur_d  [DEPTH];
    logic [CNT_W:0]    dur_q  [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [CNT_W:0] stepped;

        kev_dur_step #(.CNT_W(CNT_W)) u_step (
            .cur_i (dur_q[g]),
            .adv_i (tick_i && live_i == PTR_W'(g)),
            .nxt_o (stepped)
        );

        always_comb begin
            code_d[g] = code_q[g];
            dur_d[g]  = stepped;
            if (clr_en_i && clr_idx_i == PTR_W'(g)) begin
                code_d[g] = '1;
                dur_d[g]  = '0;
            end
            if (wr_en_i && wr_idx_i == PTR_W'(g)) begin
                code_d[g] = wr_code_i;
                dur_d[g]  = '0;
            end
            if (flush_i) begin
                code_d[g] = '1;
                dur_d[g]  = '0;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                code_q[g] <= '1;
                dur_q[g]  <= '0;
            end else begin
                code_q[g] <= code_d[g];
                dur_q[g]  <= dur_d[g];
            end
        end
    end

    assign rd_code_o = code_q[show_idx_i];
    assign rd_dur_o  = dur_q[show_idx_i];

    // R4
    of_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !wr_en_i && !flush_i && dur_q[live_i][CNT_W]) |=> dur_q[$past(live_i)][CNT_W]);

    // R5
    fresh_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !flush_i) |=> (dur_q[$past(wr_idx_i)] == '0 && code_q[$past(wr_idx_i)] == $past(wr_code_i)));
endmodule

// File: rtl/key_event_queue.sv
module key_event_queue
    import kev_pkg::*;
#(
    parameter int DEPTH  = KEV_DEPTH,
    parameter int CODE_W = KEV_CODE_W,
    parameter int CNT_W  = KEV_CNT_W,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt_n_i,
    input  logic              pwr_clr_i,
    input  logic              tick_i,
    input  logic              evt_i,
    input  logic [CODE_W-1:0] evt_code_i,
    input  logic              pop_i,
    output logic [CODE_W-1:0] rd_code_o,
    output logic [CNT_W:0]    rd_dur_o,
    output logic              empty_o,
    output logic              irq_n_o
);
    logic             flush;
    logic [PTR_W-1:0] live_ptr, wr_idx, clr_idx, show_idx;
    logic             wr_en, clr_en;

    assign flush = pwr_clr_i | ~halt_n_i;

    kev_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_i    (flush),
        .evt_i      (evt_i),
        .pop_i      (pop_i),
        .live_o     (live_ptr),
        .wr_en_o    (wr_en),
        .wr_idx_o   (wr_idx),
        .clr_en_o   (clr_en),
        .clr_idx_o  (clr_idx),
        .show_idx_o (show_idx),
        .empty_o    (empty_o),
        .irq_n_o    (irq_n_o)
    );

    kev_store #(.DEPTH(DEPTH), .CODE_W(CODE_W), .CNT_W(CNT_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_i    (flush),
        .tick_i     (tick_i),
        .live_i     (live_ptr),
        .wr_en_i    (wr_en),
        .wr_idx_i   (wr_idx),
        .wr_code_i  (evt_code_i),
        .clr_en_i   (clr_en),
        .clr_idx_i  (clr_idx),
        .show_idx_i (show_idx),
        .rd_code_o  (rd_code_o),
        .rd_dur_o   (rd_dur_o)
    );
endmodule

// File: tb/tb_key_event_queue.sv
`timescale 1ns/1ps
module tb_key_event_queue;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       halt_n = 1'b1;
    logic       pwr_clr = 1'b0;
    logic       tick = 1'b0;
    logic       evt = 1'b0;
    logic [7:0] code = 8'h00;
    logic       pop = 1'b0;
    logic [7:0] rd_code;
    logic [7:0] rd_dur;
    logic       empty;
    logic       irq_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    key_event_queue dut (
        .clk(clk), .rst_n(rst_n), .halt_n_i(halt_n), .pwr_clr_i(pwr_clr),
        .tick_i(tick), .evt_i(evt), .evt_code_i(code), .pop_i(pop),
        .rd_code_o(rd_code), .rd_dur_o(rd_dur), .empty_o(empty), .irq_n_o(irq_n)
    );

    // {evt, code, pop, tick, exp_code, exp_dur, exp_empty, exp_irq_n}
    localparam int NV = 15;
    localparam logic [28:0] VEC [NV] = '{
        {1'b0, 8'h00, 1'b0, 1'b0, 8'hFF, 8'h00, 1'b1, 1'b1}, // R1 idle
        {1'b0, 8'h00, 1'b0, 1'b1, 8'hFF, 8'h01, 1'b1, 1'b1}, // R8 live runs
        {1'b1, 8'h11, 1'b0, 1'b0, 8'h11, 8'h00, 1'b0, 1'b0}, // R2 store
        {1'b0, 8'h00, 1'b0, 1'b1, 8'h11, 8'h01, 1'b0, 1'b0}, // R3
        {1'b0, 8'h00, 1'b0, 1'b1, 8'h11, 8'h02, 1'b0, 1'b0}, // R3
        {1'b0, 8'h00, 1'b1, 1'b0, 8'h11, 8'h02, 1'b1, 1'b1}, // R7 pop live
        {1'b0, 8'h00, 1'b1, 1'b0, 8'h11, 8'h02, 1'b1, 1'b1}, // R7 again
        {1'b0, 8'h00, 1'b0, 1'b1, 8'h11, 8'h03, 1'b1, 1'b1}, // R8 running
        {1'b1, 8'h22, 1'b0, 1'b0, 8'h11, 8'h03, 1'b0, 1'b0}, // R5 freeze
        {1'b0, 8'h00, 1'b0, 1'b1, 8'h11, 8'h03, 1'b0, 1'b0}, // R5 frozen
        {1'b0, 8'h00, 1'b1, 1'b0, 8'h22, 8'h01, 1'b0, 1'b1}, // R6 release
        {1'b1, 8'h33, 1'b1, 1'b0, 8'h22, 8'h01, 1'b0, 1'b0}, // R10 pop+evt
        {1'b0, 8'h00, 1'b1, 1'b0, 8'h33, 8'h00, 1'b0, 1'b1}, // R6
        {1'b0, 8'h00, 1'b1, 1'b0, 8'h33, 8'h00, 1'b1, 1'b1}, // R7
        {1'b0, 8'h00, 1'b1, 1'b0, 8'h33, 8'h00, 1'b1, 1'b1}  // R7 repeat
    };

    task automatic chk(input string req, input logic [7:0] ec, input logic [7:0] ed,
                       input logic ee, input logic ei);
        n_chk++;
        if (rd_code !== ec || rd_dur !== ed || empty !== ee || irq_n !== ei) begin
            n_bad++;
            $display("FAIL %s: got code=%h dur=%h empty=%b irq_n=%b, exp code=%h dur=%h empty=%b irq_n=%b",
                     req, rd_code, rd_dur, empty, irq_n, ec, ed, ee, ei);
        end
    endtask

    task automatic cyc(input logic e, input logic [7:0] c, input logic p, input logic t);
        evt = e; code = c; pop = p; tick = t;
        @(negedge clk);
        evt = 1'b0; pop = 1'b0; tick = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout, exp finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset", 8'hFF, 8'h00, 1'b1, 1'b1);

        for (int i = 0; i < NV; i++) begin
            cyc(VEC[i][28], VEC[i][27:20], VEC[i][19], VEC[i][18]);
            chk($sformatf("vec%0d", i), VEC[i][17:10], VEC[i][9:2], VEC[i][1], VEC[i][0]);
        end

        // R4: overflow on live slot 0x33
        for (int i = 0; i < 127; i++) cyc(1'b0, 8'h00, 1'b0, 1'b1);
        chk("R3 count 127", 8'h33, 8'h7F, 1'b1, 1'b1);
        cyc(1'b0, 8'h00, 1'b0, 1'b1);
        chk("R4 wrap sets bit7", 8'h33, 8'h80, 1'b1, 1'b1);
        cyc(1'b0, 8'h00, 1'b0, 1'b1);
        chk("R4 sticky", 8'h33, 8'h81, 1'b1, 1'b1);
        cyc(1'b1, 8'h44, 1'b0, 1'b0);
        cyc(1'b0, 8'h00, 1'b0, 1'b1);
        chk("R4 kept after freeze", 8'h33, 8'h81, 1'b0, 1'b0);
        cyc(1'b0, 8'h00, 1'b1, 1'b0);
        chk("R6 next slot", 8'h44, 8'h01, 1'b0, 1'b1);

        // R11 power-down clear
        pwr_clr = 1'b1;
        @(negedge clk);
        pwr_clr = 1'b0;
        chk("R11 pwr clear", 8'hFF, 8'h00, 1'b1, 1'b1);
        cyc(1'b0, 8'h00, 1'b1, 1'b0);
        chk("R12 idle pop", 8'hFF, 8'h00, 1'b1, 1'b1);

        // R9 overwrite of oldest
        for (int i = 0; i < 9; i++) cyc(1'b1, 8'h50 + 8'(i), 1'b0, 1'b0);
        chk("R9 oldest dropped", 8'h51, 8'h00, 1'b0, 1'b0);
        for (int i = 0; i < 7; i++) begin
            cyc(1'b0, 8'h00, 1'b1, 1'b0);
            chk("R9 order", 8'h52 + 8'(i), 8'h00, 1'b0, 1'b1);
        end

        // R11 halt input
        halt_n = 1'b0;
        @(negedge clk);
        halt_n = 1'b1;
        chk("R11 halt", 8'hFF, 8'h00, 1'b1, 1'b1);
        cyc(1'b0, 8'h00, 1'b0, 1'b1);
        chk("R8 after halt", 8'hFF, 8'h01, 1'b1, 1'b1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule